// File: doc/BRIEF.md
# Autoincrement Block-Transfer Execution Unit

This unit executes a single load-constant instruction with post-increment for a small 8-bit controller core. It moves one byte between byte-wide program memory and the register file. The program-memory address comes from a 16-bit pointer held in a pair of working registers. The register-file address comes from an 8-bit pointer held in one working register. After the move, both pointers advance by one. Repeated issues of the instruction therefore walk a block of data in either direction.

The core presents the opcode byte and the operand byte together with a one-cycle start strobe. Opcode C3h copies program memory into the register file. Opcode D3h copies the register file into program memory. Any other opcode is refused.

The unit keeps sixteen 8-bit working registers of its own. While the unit is idle, the core can load them and read them through a side port. Both memory ports use plain single-cycle strobes with a fixed read latency of one cycle, so no back-pressure applies. The unit holds no status flags and touches none.

Top module: `ldci_xfer_unit`

## Requirements
- R1: With opcode C3h, the unit raises `pm_rd` once, with `pm_addr` equal to the source register pair. It then raises `rf_wr` once, with `rf_addr` equal to the destination working register, and writes the byte that was read.
- R2: With opcode D3h, the unit raises `rf_rd` once, with `rf_addr` equal to the source working register. It then raises `pm_wr` once, with `pm_addr` equal to the destination register pair, and writes the byte that was read. `pm_wr` and `rf_wr` are never high in the same cycle.
- R3: The operand byte is decoded as follows. Bits 7:4 name the destination register and bits 3:0 name the source register. A pair field ignores its bit 0. The even register holds the address bits 15:8 and the next odd register holds bits 7:0.
- R4: When the move is done, the 8-bit pointer register increases by one and wraps from FFh to 00h. The 16-bit pair increases by one, carries from the low byte into the high byte, and wraps from FFFFh to 0000h.
- R5: After a start is accepted, `busy` stays high and `done` is high for exactly one cycle. That cycle is the 18th cycle after the accepting clock edge, and `busy` falls after it.
- R6: A `start` that arrives while `busy` is high is ignored. It does not restart the count, add strobes or produce a second `done`.
- R7: An opcode other than C3h or D3h raises `illegal` together with `done`. No memory strobe is issued and no working register changes.
- R8: Each legal instruction issues exactly one read strobe and one write strobe. The source location keeps its value.
- R9: `wreg_ld` writes `wreg_ld_data` into working register `wreg_ld_idx` only while the unit is idle. It is ignored while `busy` is high. `wreg_peek_data` always shows register `wreg_peek_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (single-cycle strobe) |
| opcode | input | 8 | First instruction byte |
| operand | input | 8 | Second instruction byte: destination and source register numbers |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | High with `done` when the opcode was refused |
| pm_addr | output | 16 | Program memory address |
| pm_rd | output | 1 | Program memory read strobe; data is returned the next cycle |
| pm_wr | output | 1 | Program memory write strobe |
| pm_wdata | output | 8 | Program memory write data |
| pm_rdata | input | 8 | Program memory read data |
| rf_addr | output | 8 | Register file address |
| rf_rd | output | 1 | Register file read strobe; data is returned the next cycle |
| rf_wr | output | 1 | Register file write strobe |
| rf_wdata | output | 8 | Register file write data |
| rf_rdata | input | 8 | Register file read data |
| wreg_ld | input | 1 | Working register load strobe |
| wreg_ld_idx | input | 4 | Working register to load |
| wreg_ld_data | input | 8 | Load value |
| wreg_peek_idx | input | 4 | Working register to observe |
| wreg_peek_data | output | 8 | Value of the observed register |

## Verification
Assertions check several properties on every cycle:
- the completion pulse lasts one cycle;
- the unit stays busy until it finishes, and a start that arrives mid-run does not disturb the count;
- the two memory ports never write in the same cycle;
- a refused opcode issues no strobes;
- when the pointer and the pair do not overlap, the pointer register and the register pair each advance by exactly one.

Only the bench scenarios can show the rest:
- that the correct byte reaches the correct address, for both opcodes;
- the nibble decode, including an odd pair number;
- the carry and both wrap-arounds;
- that the completion cycle is the eighteenth;
- that loads are ignored while the unit is busy.

// File: rtl/ldci_pkg.sv
package ldci_pkg;
  typedef enum logic [1:0] {
    K_NONE    = 2'd0,
    K_MEM2REG = 2'd1,
    K_REG2MEM = 2'd2
  } xfer_kind_e;

  localparam logic [7:0] OPC_MEM2REG = 8'hC3;
  localparam logic [7:0] OPC_REG2MEM = 8'hD3;

  // phase numbers within the instruction, counted from 1 after the accepting edge
  localparam int PH_READ = 2;
  localparam int PH_CAPT = 3;
  localparam int PH_WRITE = 4;
  localparam int PH_INCR = 5;

  function automatic xfer_kind_e decode_kind(input logic [7:0] op);
    case (op)
      OPC_MEM2REG: decode_kind = K_MEM2REG;
      OPC_REG2MEM: decode_kind = K_REG2MEM;
      default:     decode_kind = K_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ldci_seq.sv
module ldci_seq #(
  parameter int LAT = 18,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          accept,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic          done
);
  assign accept = start && !busy;
  assign done   = busy && (cnt == CW'(LAT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= CW'(1);
    end else if (busy) begin
      if (cnt == CW'(LAT)) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5: completion is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: once running, stay busy until the completion cycle
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R6: a start during a run does not restart the count
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/ldci_wreg_bank.sv
module ldci_wreg_bank #(
  parameter int DW = 8,
  parameter int NREG = 16,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_en,
  input  logic [RIW-1:0] ld_idx,
  input  logic [DW-1:0]  ld_data,
  input  logic [RIW-1:0] peek_idx,
  output logic [DW-1:0]  peek_data,
  input  logic [RIW-1:0] ptr_idx,
  input  logic [RIW-1:0] pair_idx,
  input  logic           inc_en,
  output logic [DW-1:0]  ptr_val,
  output logic [2*DW-1:0] pair_val
);
  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] nxt  [NREG];
  logic [RIW-1:0] hi_idx, lo_idx;
  logic [2*DW-1:0] pair_inc;

  assign hi_idx    = {pair_idx[RIW-1:1], 1'b0};
  assign lo_idx    = {pair_idx[RIW-1:1], 1'b1};
  assign pair_val  = {regs[hi_idx], regs[lo_idx]};
  assign ptr_val   = regs[ptr_idx];
  assign peek_data = regs[peek_idx];
  assign pair_inc  = pair_val + 1'b1;

  always_comb begin
    for (int i = 0; i < NREG; i++) nxt[i] = regs[i];
    if (inc_en) begin
      nxt[hi_idx]  = pair_inc[2*DW-1:DW];
      nxt[lo_idx]  = pair_inc[DW-1:0];
      nxt[ptr_idx] = nxt[ptr_idx] + 1'b1;
    end else if (ld_en) begin
      nxt[ld_idx] = ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) regs[i] <= nxt[i];
    end
  end

  // R4: the 8-bit pointer advances by one when it does not overlap the pair
  p_ptr_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && ptr_idx != hi_idx && ptr_idx != lo_idx)
      |=> (regs[$past(ptr_idx)] == $past(regs[ptr_idx]) + 1'b1));

  // R4: the 16-bit pair advances by one, with carry and wrap
  p_pair_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && ptr_idx != hi_idx && ptr_idx != lo_idx)
      |=> ({regs[$past(hi_idx)], regs[$past(lo_idx)]} == $past(pair_val) + 1'b1));
endmodule

// File: rtl/ldci_xfer_unit.sv
module ldci_xfer_unit
  import ldci_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NREG = 16,
  parameter int LAT = 18,
  localparam int RIW = $clog2(NREG),
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [7:0]     opcode,
  input  logic [7:0]     operand,
  output logic           busy,
  output logic           done,
  output logic           illegal,
  output logic [AW-1:0]  pm_addr,
  output logic           pm_rd,
  output logic           pm_wr,
  output logic [DW-1:0]  pm_wdata,
  input  logic [DW-1:0]  pm_rdata,
  output logic [DW-1:0]  rf_addr,
  output logic           rf_rd,
  output logic           rf_wr,
  output logic [DW-1:0]  rf_wdata,
  input  logic [DW-1:0]  rf_rdata,
  input  logic           wreg_ld,
  input  logic [RIW-1:0] wreg_ld_idx,
  input  logic [DW-1:0]  wreg_ld_data,
  input  logic [RIW-1:0] wreg_peek_idx,
  output logic [DW-1:0]  wreg_peek_data
);
  logic           accept;
  logic [CW-1:0]  cnt;
  xfer_kind_e     kind_q;
  logic [RIW-1:0] dst_q, src_q;
  logic [DW-1:0]  data_q;
  logic [RIW-1:0] ptr_idx, pair_idx;
  logic [DW-1:0]  ptr_val;
  logic [2*DW-1:0] pair_val;
  logic ph_read, ph_capt, ph_write, inc_en;

  ldci_seq #(.LAT(LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .accept(accept), .busy(busy), .cnt(cnt), .done(done)
  );

  // capture the instruction on the accepting edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= K_NONE;
      dst_q  <= '0;
      src_q  <= '0;
    end else if (accept) begin
      kind_q <= decode_kind(opcode);
      dst_q  <= operand[7:4];
      src_q  <= operand[3:0];
    end
  end

  // the pointer side and the pair side swap with the direction
  assign ptr_idx  = (kind_q == K_REG2MEM) ? src_q : dst_q;
  assign pair_idx = (kind_q == K_REG2MEM) ? dst_q : src_q;

  assign ph_read  = busy && (cnt == CW'(PH_READ));
  assign ph_capt  = busy && (cnt == CW'(PH_CAPT));
  assign ph_write = busy && (cnt == CW'(PH_WRITE));
  assign inc_en   = busy && (cnt == CW'(PH_INCR)) && (kind_q != K_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) data_q <= '0;
    else if (ph_capt) data_q <= (kind_q == K_MEM2REG) ? pm_rdata : rf_rdata;
  end

  ldci_wreg_bank #(.DW(DW), .NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .ld_en(wreg_ld && !busy), .ld_idx(wreg_ld_idx), .ld_data(wreg_ld_data),
    .peek_idx(wreg_peek_idx), .peek_data(wreg_peek_data),
    .ptr_idx(ptr_idx), .pair_idx(pair_idx), .inc_en(inc_en),
    .ptr_val(ptr_val), .pair_val(pair_val)
  );

  assign pm_addr  = AW'(pair_val);
  assign rf_addr  = ptr_val;
  assign pm_wdata = data_q;
  assign rf_wdata = data_q;
  assign pm_rd    = ph_read  && (kind_q == K_MEM2REG);
  assign rf_rd    = ph_read  && (kind_q == K_REG2MEM);
  assign rf_wr    = ph_write && (kind_q == K_MEM2REG);
  assign pm_wr    = ph_write && (kind_q == K_REG2MEM);
  assign illegal  = done && (kind_q == K_NONE);

  // R2: never write both memories at once
  p_one_writer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_wr && rf_wr));

  // R7: a refused opcode touches no memory
  p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_q == K_NONE) |-> !(pm_rd || pm_wr || rf_rd || rf_wr));

  // R8: strobes happen only inside a run
  p_strobe_in_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_rd || pm_wr || rf_rd || rf_wr) |-> busy);
endmodule

// File: tb/ldci_xfer_unit_test.sv
`timescale 1ns/1ps
module ldci_xfer_unit_test;
  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [7:0] opcode = 0, operand = 0;
  logic busy, done, illegal;
  logic [15:0] pm_addr;
  logic pm_rd, pm_wr, rf_rd, rf_wr;
  logic [7:0] pm_wdata, rf_wdata, rf_addr;
  logic [7:0] pm_rdata = 0, rf_rdata = 0;
  logic wreg_ld = 0;
  logic [3:0] wreg_ld_idx = 0, wreg_peek_idx = 0;
  logic [7:0] wreg_ld_data = 0, wreg_peek_data;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ldci_xfer_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .operand(operand),
    .busy(busy), .done(done), .illegal(illegal),
    .pm_addr(pm_addr), .pm_rd(pm_rd), .pm_wr(pm_wr), .pm_wdata(pm_wdata), .pm_rdata(pm_rdata),
    .rf_addr(rf_addr), .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .wreg_ld(wreg_ld), .wreg_ld_idx(wreg_ld_idx), .wreg_ld_data(wreg_ld_data),
    .wreg_peek_idx(wreg_peek_idx), .wreg_peek_data(wreg_peek_data)
  );

  // memory models, pre-loaded through poke signals
  logic [7:0] pm_mem [256];
  logic [7:0] rf_mem [256];
  logic poke_pm = 0, poke_rf = 0;
  logic [7:0] poke_addr = 0, poke_data = 0;
  int n_pm_rd = 0, n_pm_wr = 0, n_rf_rd = 0, n_rf_wr = 0;
  logic [15:0] last_pm_addr = 0;
  logic [7:0] last_rf_addr = 0, last_wdata = 0;

  always @(posedge clk) begin
    if (poke_pm) pm_mem[poke_addr] <= poke_data;
    if (poke_rf) rf_mem[poke_addr] <= poke_data;
    if (pm_rd) begin pm_rdata <= pm_mem[pm_addr[7:0]]; n_pm_rd <= n_pm_rd + 1; last_pm_addr <= pm_addr; end
    if (rf_rd) begin rf_rdata <= rf_mem[rf_addr]; n_rf_rd <= n_rf_rd + 1; last_rf_addr <= rf_addr; end
    if (pm_wr) begin pm_mem[pm_addr[7:0]] <= pm_wdata; n_pm_wr <= n_pm_wr + 1; last_pm_addr <= pm_addr; last_wdata <= pm_wdata; end
    if (rf_wr) begin rf_mem[rf_addr] <= rf_wdata; n_rf_wr <= n_rf_wr + 1; last_rf_addr <= rf_addr; last_wdata <= rf_wdata; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input bit to_pm, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    poke_pm = to_pm; poke_rf = !to_pm; poke_addr = a; poke_data = d;
    @(negedge clk);
    poke_pm = 0; poke_rf = 0;
  endtask

  task automatic wload(input logic [3:0] idx, input logic [7:0] val);
    @(negedge clk);
    wreg_ld = 1; wreg_ld_idx = idx; wreg_ld_data = val;
    @(negedge clk);
    wreg_ld = 0;
  endtask

  task automatic peek(input logic [3:0] idx, output logic [7:0] val);
    @(negedge clk);
    wreg_peek_idx = idx;
    #1 val = wreg_peek_data;
  endtask

  // run one instruction; at cycle extra_k optionally restart (mode 1) or load R0 (mode 2)
  task automatic run(input logic [7:0] op, input logic [7:0] opd, input int extra_k,
                     input int mode, output int done_k, output int n_done, output bit ill);
    done_k = 0; n_done = 0; ill = 0;
    @(negedge clk);
    start = 1; opcode = op; operand = opd;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      start = 0; wreg_ld = 0;
      if (done) begin n_done++; if (done_k == 0) done_k = k; ill = illegal; end
      if (k == extra_k && mode == 1) begin start = 1; opcode = 8'hD3; operand = 8'h62; end
      if (k == extra_k && mode == 2) begin wreg_ld = 1; wreg_ld_idx = 4'd0; wreg_ld_data = 8'hAA; end
    end
    start = 0; wreg_ld = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R5 busy after reset", busy, 0);
    chk("R5 done after reset", done, 0);
    peek(4'd6, v);
    chk("R9 register cleared by reset", v, 8'h00);
  endtask

  task automatic t_mem2reg;
    int dk, nd, p0, p1; bit il; logic [7:0] v, w;
    wload(4'd6, 8'h30); wload(4'd7, 8'hA2); wload(4'd2, 8'h20);
    peek(4'd2, v); chk("R9 load while idle", v, 8'h20);
    poke(1, 8'hA2, 8'h22); poke(1, 8'hA3, 8'hBC);
    p0 = n_pm_rd; p1 = n_rf_wr;
    run(8'hC3, 8'h26, 0, 0, dk, nd, il);
    chk("R5 done on cycle 18", dk, 18);
    chk("R5 single done pulse", nd, 1);
    chk("R7 no illegal on C3", il, 0);
    chk("R1 read address is the pair", last_pm_addr, 16'h30A2);
    chk("R1 byte written to register file", rf_mem[8'h20], 8'h22);
    chk("R8 one read strobe", n_pm_rd - p0, 1);
    chk("R8 one write strobe", n_rf_wr - p1, 1);
    chk("R8 source byte unchanged", pm_mem[8'hA2], 8'h22);
    peek(4'd6, v); peek(4'd7, w);
    chk("R4 pair advanced", {v, w}, 16'h30A3);
    peek(4'd2, v); chk("R4 pointer advanced", v, 8'h21);
    run(8'hC3, 8'h26, 0, 0, dk, nd, il);
    chk("R1 second run moves next byte", rf_mem[8'h21], 8'hBC);
  endtask

  task automatic t_reg2mem;
    int dk, nd; bit il; logic [7:0] v, w;
    wload(4'd4, 8'h12); wload(4'd5, 8'hFF); wload(4'd9, 8'h40);
    poke(0, 8'h40, 8'h5A);
    run(8'hD3, 8'h49, 0, 0, dk, nd, il);
    chk("R2 done on cycle 18", dk, 18);
    chk("R2 write address is the pair", last_pm_addr, 16'h12FF);
    chk("R2 byte written to program memory", pm_mem[8'hFF], 8'h5A);
    chk("R8 register-file source unchanged", rf_mem[8'h40], 8'h5A);
    peek(4'd4, v); peek(4'd5, w);
    chk("R4 carry into high byte", {v, w}, 16'h1300);
    peek(4'd9, v); chk("R4 pointer advanced on D3", v, 8'h41);
  endtask

  task automatic t_wrap;
    int dk, nd; bit il; logic [7:0] v, w;
    wload(4'd8, 8'hFF); wload(4'd9, 8'hFF); wload(4'd3, 8'hFF);
    poke(1, 8'hFF, 8'h77);
    run(8'hC3, 8'h38, 0, 0, dk, nd, il);
    chk("R4 byte at wrap addresses", rf_mem[8'hFF], 8'h77);
    peek(4'd8, v); peek(4'd9, w);
    chk("R4 pair wraps to 0000", {v, w}, 16'h0000);
    peek(4'd3, v); chk("R4 pointer wraps to 00", v, 8'h00);
  endtask

  task automatic t_odd_pair;
    int dk, nd; bit il;
    wload(4'd6, 8'h00); wload(4'd7, 8'h10); wload(4'd1, 8'h30);
    poke(1, 8'h10, 8'h99);
    run(8'hC3, 8'h17, 0, 0, dk, nd, il);
    chk("R3 odd pair number uses even pair", last_pm_addr, 16'h0010);
    chk("R3 destination from upper nibble", rf_mem[8'h30], 8'h99);
  endtask

  task automatic t_illegal;
    int dk, nd, s0; bit il; logic [7:0] v;
    wload(4'd2, 8'h55);
    s0 = n_pm_rd + n_pm_wr + n_rf_rd + n_rf_wr;
    run(8'hC2, 8'h26, 0, 0, dk, nd, il);
    chk("R7 done on cycle 18", dk, 18);
    chk("R7 illegal raised with done", il, 1);
    chk("R7 no strobes", n_pm_rd + n_pm_wr + n_rf_rd + n_rf_wr - s0, 0);
    peek(4'd2, v); chk("R7 register unchanged", v, 8'h55);
  endtask

  task automatic t_busy_start;
    int dk, nd, s0; bit il;
    wload(4'd6, 8'h00); wload(4'd7, 8'h50); wload(4'd2, 8'h60);
    poke(1, 8'h50, 8'h3C);
    s0 = n_pm_rd + n_pm_wr + n_rf_rd + n_rf_wr;
    run(8'hC3, 8'h26, 5, 1, dk, nd, il);
    chk("R6 done still on cycle 18", dk, 18);
    chk("R6 no second done", nd, 1);
    chk("R6 only two strobes", n_pm_rd + n_pm_wr + n_rf_rd + n_rf_wr - s0, 2);
    chk("R6 first instruction result", rf_mem[8'h60], 8'h3C);
  endtask

  task automatic t_load_busy;
    int dk, nd; bit il; logic [7:0] v;
    wload(4'd0, 8'h11); wload(4'd6, 8'h00); wload(4'd7, 8'h20); wload(4'd2, 8'h70);
    run(8'hC3, 8'h26, 8, 2, dk, nd, il);
    peek(4'd0, v); chk("R9 load ignored while busy", v, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mem2reg();
    t_reg2mem();
    t_wrap();
    t_odd_pair();
    t_illegal();
    t_busy_start();
    t_load_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule